// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block is a synchronous front end for an external asynchronous static RAM that has a 17-bit word address, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write enable. A client inside the chip hands it one read or write at a time through a valid/ready handshake. The controller latches the request and plays out the strobe sequence on the memory pins. Every phase lasts a number of system clocks set by parameters; with a 100 MHz clock the defaults meet the RAM's 10 ns access and write timing. Read data comes back on `rspData` together with a one-cycle `rspDone` pulse. A write also ends with a `rspDone` pulse.

The memory treats chip select high as deselected, with its outputs floating. With chip select low it reads when write enable is high and output enable is low. It writes while write enable is low. With both write enable and output enable high it only turns its outputs off. A write lasts only while chip select and write enable are both low, and data setup is counted from the end of that overlap. The controller keeps output enable high for the whole of every write, so the shortest write pulse is enough. It drives the data bus only while it is writing. When a write follows a read, it adds an idle turnaround gap so that the RAM has released the bus before the controller drives it. Between requests chip select stays high, which puts the RAM into standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select, output enable and write enable are all high (1), `reqReady` is 1 and `rspDone` is 0.
- R2: A read holds chip select and output enable low with write enable high for exactly RD_CYC cycles (default 2). It captures the bus at the end of the last of those cycles. `rspData` shows the stored byte in the following cycle.
- R3: A write holds write enable low for exactly WR_CYC cycles (default 1). During those cycles chip select is low and output enable is high.
- R4: Address and write data are on the pins for SETUP_CYC cycles before write enable falls and for HOLD_CYC cycles after it rises. The write ends on the rise of write enable while chip select is still low, and the byte on the bus while write enable is low equals the requested data.
- R5: The controller drives the data bus only during the write phases. Output enable is never low during a write, so the controller and the RAM never drive the bus together.
- R6: When a write is accepted right after a read, chip select stays high for 1+TURN_CYC cycles (default 2) between the last read cycle and the first write cycle. Between two writes the gap is one cycle.
- R7: `rspDone` is a one-cycle pulse in the first cycle after an operation ends. `rspData` changes only when a read completes, so a write leaves it unchanged.
- R8: When no request is in progress, chip select is high and `reqReady` is 1. Only one request is accepted at a time.
- R9: Address, data and operation are latched when the request is accepted. Changes on `reqAddr`, `reqWdata` and `reqWrite` after acceptance do not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 8 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Last read byte |
| memAddr | output | 17 | RAM address pins |
| memCeN | output | 1 | RAM chip select, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memData | inout | 8 | RAM data bus, tri-state |

## Verification
A vector table first writes bytes and then reads them back. One read goes to an address that differs from a written one only in its upper bits and expects the model's empty marker, which shows that the full address reaches the pins. Random writes followed by reads across many slots exercise read-after-write data. A read followed at once by a write, compared with a write followed at once by a write, shows that the turnaround gap appears only when the bus changes direction. Changing the request inputs right after acceptance shows that the operation uses the values latched at acceptance.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_RD,
    S_WSU,
    S_WPW,
    S_WHD
  } ctrlState_e;

  // Strobes from control to datapath: pin levels for the next cycle
  // plus single-cycle actions applied at the coming edge.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic load;
    logic capture;
    logic finish;
  } busCtl_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 1,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output busCtl_t ctl
);

  localparam int MAX_A   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_B   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  ctrlState_e       state, nxt;
  logic [CNT_W-1:0] cnt, lim;
  logic             atLim;
  logic             lastRead;

  always_comb begin
    unique case (state)
      S_TURN:  lim = CNT_W'(TURN_CYC - 1);
      S_RD:    lim = CNT_W'(RD_CYC - 1);
      S_WSU:   lim = CNT_W'(SETUP_CYC - 1);
      S_WPW:   lim = CNT_W'(WR_CYC - 1);
      S_WHD:   lim = CNT_W'(HOLD_CYC - 1);
      default: lim = '0;
    endcase
  end

  assign atLim = (cnt == lim);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (reqValid) nxt = !reqWrite ? S_RD : (lastRead ? S_TURN : S_WSU);
      S_TURN: if (atLim) nxt = S_WSU;
      S_RD:   if (atLim) nxt = S_IDLE;
      S_WSU:  if (atLim) nxt = S_WPW;
      S_WPW:  if (atLim) nxt = S_WHD;
      S_WHD:  if (atLim) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  function automatic busCtl_t pinsFor(ctrlState_e s);
    busCtl_t p;
    p = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0,
          load: 1'b0, capture: 1'b0, finish: 1'b0};
    unique case (s)
      S_RD:  begin p.ceN = 1'b0; p.oeN = 1'b0; end
      S_WSU: begin p.ceN = 1'b0; p.drive = 1'b1; end
      S_WPW: begin p.ceN = 1'b0; p.weN = 1'b0; p.drive = 1'b1; end
      S_WHD: begin p.ceN = 1'b0; p.drive = 1'b1; end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    ctl         = pinsFor(nxt);
    ctl.load    = (state == S_IDLE) && reqValid;
    ctl.capture = (state == S_RD) && atLim;
    ctl.finish  = atLim && ((state == S_RD) || (state == S_WHD));
  end

  assign reqReady = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      state <= nxt;
      if ((nxt != state) || (state == S_IDLE)) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (ctl.load) lastRead <= !reqWrite;
    end
  end

  // R4: the write pulse is always entered from the setup phase
  a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WPW && $past(state) != S_WPW) |-> $past(state) == S_WSU);

  // R8: an accepted request leaves idle, so no second one is taken
  a_r8_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> state != S_IDLE);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  logic              ceQ, oeQ, weQ, driveQ, doneQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceQ    <= 1'b1;
      oeQ    <= 1'b1;
      weQ    <= 1'b1;
      driveQ <= 1'b0;
      doneQ  <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      ceQ    <= ctl.ceN;
      oeQ    <= ctl.oeN;
      weQ    <= ctl.weN;
      driveQ <= ctl.drive;
      doneQ  <= ctl.finish;
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdataQ <= memData;
    end
  end

  assign memAddr = addrQ;
  assign memCeN  = ceQ;
  assign memOeN  = oeQ;
  assign memWeN  = weQ;
  assign memData = driveQ ? wdataQ : {DATA_W{1'bz}};
  assign rspData = rdataQ;
  assign rspDone = doneQ;

  // R3: write enable low only while selected with outputs disabled
  a_r3_we_window: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (memOeN && !memCeN && driveQ));

  // R4: the write is ended by write enable rising, chip select still low
  a_r4_we_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> (!memCeN && driveQ));

  // R5: never drive the bus while the RAM may be driving it
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    driveQ |-> memOeN);

  // R6: two quiet cycles before the controller starts driving
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(driveQ) |-> ($past(memOeN) && $past(memOeN, 2)));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rspDone |=> !rspDone);

  // R8: the RAM is deselected when an operation has completed
  a_r8_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    rspDone |-> (memCeN && !driveQ));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 1,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memData
);

  busCtl_t ctl;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ctl(ctl)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memData(memData),
    .rspData(rspData), .rspDone(rspDone)
  );

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspDone, memCeN, memOeN, memWeN;
  logic [7:0]  rspData;
  logic [16:0] memAddr;
  wire  [7:0]  memData;

  int checks = 0, errors = 0;

  sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memData(memData)
  );

  // Behavioural RAM: 64 slots on the low address bits, each tagged with the full address.
  logic [7:0]  ramData [64];
  logic [16:0] ramTag  [64];
  logic        ramUsed [64];
  logic [7:0]  ramOut;
  wire ramDrive = !memCeN && !memOeN && memWeN;

  always_comb begin
    ramOut = 8'hEE;
    if (ramUsed[memAddr[5:0]] && ramTag[memAddr[5:0]] == memAddr)
      ramOut = ramData[memAddr[5:0]];
  end
  assign memData = ramDrive ? ramOut : 8'bz;

  always @(posedge memWeN) if (memCeN === 1'b0) begin
    ramData[memAddr[5:0]] <= memData;
    ramTag[memAddr[5:0]]  <= memAddr;
    ramUsed[memAddr[5:0]] <= 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int mRd, mWe;
  bit mOeBad, mWeEnd, mDoneAfter, mCeAfter;
  logic [7:0] mBus, mRdata;

  task automatic runOp(input bit wr, input logic [16:0] a, input logic [7:0] d);
    bit prevWe;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = !wr; reqAddr = ~a; reqWdata = ~d;
    mRd = 0; mWe = 0; mOeBad = 0; mWeEnd = 1; mBus = '0; prevWe = 0;
    for (int i = 0; i < 40 && !rspDone; i++) begin
      if (!memCeN && !memOeN) mRd++;
      if (!memWeN) begin
        mWe++; mBus = memData;
        if (!memOeN || memCeN) mOeBad = 1;
      end
      if (wr && !memCeN && !memOeN) mOeBad = 1;
      if (prevWe && memWeN && memCeN) mWeEnd = 0;
      prevWe = !memWeN;
      @(negedge clk);
    end
    mRdata = rspData;
    mCeAfter = memCeN && reqReady;
    @(negedge clk);
    mDoneAfter = rspDone;
  endtask

  // Two back-to-back requests with valid held; returns chip-select-high cycles between them.
  task automatic measureGap(input bit firstWr, input logic [16:0] a1, input logic [7:0] d1,
                            input logic [16:0] a2, input logic [7:0] d2, output int gap);
    int phase;
    bit dropNext;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = firstWr; reqAddr = a1; reqWdata = d1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = a2; reqWdata = d2;
    phase = 0; gap = 0; dropNext = 0;
    for (int i = 0; i < 40 && phase != 2; i++) begin
      if (dropNext) begin reqValid = 1'b0; dropNext = 0; end
      if (reqReady && reqValid) dropNext = 1;
      if (phase == 0 && memCeN) phase = 1;
      if (phase == 1) begin
        if (memCeN) gap++;
        else phase = 2;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int i = 0; i < 40 && !rspDone; i++) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [25:0] VEC [12] = '{
    {1'b1, 17'h1FFFF, 8'hA5},
    {1'b1, 17'h00000, 8'h5A},
    {1'b1, 17'h15501, 8'h3C},
    {1'b1, 17'h0AA42, 8'hC3},
    {1'b0, 17'h1FFFF, 8'hA5},
    {1'b0, 17'h00000, 8'h5A},
    {1'b0, 17'h0AA42, 8'hC3},
    {1'b0, 17'h15501, 8'h3C},
    {1'b0, 17'h0FFFF, 8'hEE},
    {1'b1, 17'h00000, 8'hFF},
    {1'b0, 17'h00000, 8'hFF},
    {1'b0, 17'h1FFFF, 8'hA5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    logic [16:0] expA [16];
    logic [7:0]  expD [16];
    for (int i = 0; i < 64; i++) ramUsed[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk("R1 ceN in reset", memCeN, 1);
    chk("R1 oeN in reset", memOeN, 1);
    chk("R1 weN in reset", memWeN, 1);
    chk("R1 done in reset", rspDone, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", reqReady, 1);
    chk("R1 ceN after reset", memCeN, 1);

    for (int v = 0; v < 12; v++) begin
      runOp(VEC[v][25], VEC[v][24:8], VEC[v][7:0]);
      if (VEC[v][25]) begin
        chk("R3 we low cycles", mWe, 1);
        chk("R4 bus during write", mBus, VEC[v][7:0]);
        chk("R4 write ended by we", mWeEnd, 1);
        chk("R5 oe high through write", mOeBad, 0);
      end else begin
        chk("R2 read strobe cycles", mRd, 2);
        chk("R9 read data", mRdata, VEC[v][7:0]);
      end
      chk("R7 done one cycle", mDoneAfter, 0);
      chk("R8 idle standby", mCeAfter, 1);
    end

    // R7: a write leaves rspData holding the last read byte (A5)
    runOp(1'b1, 17'h00007, 8'h11);
    chk("R7 rdata kept over write", mRdata, 8'hA5);

    // R6: read then write needs 1+TURN_CYC gap, write then write needs 1
    measureGap(1'b0, 17'h00007, 8'h00, 17'h12345, 8'h77, gap);
    chk("R6 read-to-write gap", gap, 2);
    measureGap(1'b1, 17'h00008, 8'h88, 17'h00009, 8'h99, gap);
    chk("R6 write-to-write gap", gap, 1);
    runOp(1'b0, 17'h12345, 8'h00);
    chk("R6 data after turnaround", mRdata, 8'h77);
    runOp(1'b0, 17'h00009, 8'h00);
    chk("R6 data after back-to-back writes", mRdata, 8'h99);

    // R2 R9: random read-after-write over slots 16..31
    for (int i = 0; i < 16; i++) begin
      expA[i] = {11'($urandom), 6'(i + 16)};
      expD[i] = 8'($urandom);
      runOp(1'b1, expA[i], expD[i]);
    end
    for (int i = 0; i < 16; i++) begin
      runOp(1'b0, expA[i], 8'h00);
      chk("R9 random readback", mRdata, expD[i]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule